// File: doc/BRIEF.md
# Stochastic Rounding Unit with Signed Saturation

This peripheral narrows a wide signed fixed-point value to a 32-bit signed result. A typical source is the 64-bit product of two 32-bit Q-format numbers. A bus master loads the wide value as two 32-bit words. It then writes a right-shift count, which selects how many low fraction bits are dropped.

The rounding is stochastic. Before truncation, a pseudo-random addend is added to the operand. The addend is clipped so that only the bits about to be discarded can receive random bits. The chance of rounding up therefore equals the discarded fraction, and the result carries no bias on average. Results that do not fit in 32 bits are clamped to the most positive or most negative code and never wrap.

The master reaches the unit through a zero-wait-state AHB-Lite slave port. It polls a status word until the unit is idle, then reads the result. A writable seed makes the random sequence repeatable.

Top module: `sround_sat_unit`

## Requirements
- R1: After reset, the result, status and shift-count registers all read as zero.
- R2: A transfer is accepted when hsel and hready are high and htrans is NONSEQ (2'b10) or SEQ (2'b11). Every transfer completes with no wait state (hreadyout=1) and an OKAY response (hresp=0). The word map is:
  - 0x00 and 0x04 hold the low and high operand words. Both can be read back.
  - 0x08 holds the shift count in bits 4:0. It is readable, and writing it starts an operation.
  - 0x0C is the read-only result.
  - 0x10 is status: bit 0 busy, bit 1 saturated.
  - 0x14 is the seed. It is write-only and reads as zero.
- R3: With operand X = {word 0x04, word 0x00} taken as signed 64-bit, the result is the signed saturation of floor((X + (r AND (2^n − 1))) / 2^n). Here n is the shift count and r is the current generator output.
- R4: The generator state is x, y, z, w (32 bits each) and a carry bit c. Its output is x+y+w mod 2^32. One step performs these updates:
  - y ^= y<<5, then y ^= y>>7, then y ^= y<<22.
  - t = z+w+c (mod 2^32); then z=w, c=t[31] and w=t with bit 31 cleared.
  - x += 1411392427.
- R5: The generator steps exactly once for each operation with a non-zero shift count and holds its state otherwise.
- R6: A shift count of zero adds nothing, returns the operand's value subject only to saturation, and leaves the generator unchanged.
- R7: A value above 2^31−1 gives 0x7FFFFFFF and a value below −2^31 gives 0x80000000. Either case sets status bit 1. An in-range result clears it.
- R8: Busy reads 1 in the two cycles after the shift-count write's data phase. The result and status update at the second following clock edge, when busy drops.
- R9: A write to the shift count while busy is ignored: it neither changes the count nor starts an operation.
- R10: Writing value s to the seed loads x=s, y=987654321, z=43219876, w=6543217, c=0. Reset loads the same state with s=123456789.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hready | input | 1 | Previous transfer complete |
| hwdata | input | 32 | Write data |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Always 1 (no wait states) |
| hresp | output | 1 | Always 0 (OKAY) |

## Verification
The hardest case to produce from the ports is a shift-count write that arrives while an operation is still in flight. Plain two-cycle bus writes issued back to back place the second data phase exactly on the edge where the first operation is still busy. The bench uses that timing, then shows the count and the generator position are unchanged. Generator stepping rules are exposed indirectly: a reference model of the generator predicts every result, so a skipped or extra step shows up in the next rounded value, including after zero-shift operations and seed reloads.

// File: rtl/sround_pkg.sv
`timescale 1ns/1ps
package sround_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] x;
    logic [WORD_W-1:0] y;
    logic [WORD_W-1:0] z;
    logic [WORD_W-1:0] w;
    logic              c;
  } gen_state_t;

  localparam logic [WORD_W-1:0] GEN_X_RST = 32'd123456789;
  localparam logic [WORD_W-1:0] GEN_Y0    = 32'd987654321;
  localparam logic [WORD_W-1:0] GEN_Z0    = 32'd43219876;
  localparam logic [WORD_W-1:0] GEN_W0    = 32'd6543217;
  localparam logic [WORD_W-1:0] GEN_XINC  = 32'd1411392427;

  function automatic gen_state_t gen_seeded(input logic [WORD_W-1:0] s);
    gen_state_t n;
    n.x = s;
    n.y = GEN_Y0;
    n.z = GEN_Z0;
    n.w = GEN_W0;
    n.c = 1'b0;
    return n;
  endfunction

  function automatic gen_state_t gen_advance(input gen_state_t s);
    gen_state_t n;
    logic [WORD_W-1:0] yv, t;
    yv  = s.y ^ (s.y << 5);
    yv  = yv ^ (yv >> 7);
    yv  = yv ^ (yv << 22);
    t   = s.z + s.w + {{(WORD_W-1){1'b0}}, s.c};
    n.x = s.x + GEN_XINC;
    n.y = yv;
    n.z = s.w;
    n.c = t[WORD_W-1];
    n.w = {1'b0, t[WORD_W-2:0]};
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] gen_output(input gen_state_t s);
    return s.x + s.y + s.w;
  endfunction
endpackage

// File: rtl/sround_prng.sv
`timescale 1ns/1ps
module sround_prng
  import sround_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_wr,
  input  logic [WORD_W-1:0] seed,
  input  logic              step,
  output logic [WORD_W-1:0] rnd
);
  gen_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= gen_seeded(GEN_X_RST);
    else if (seed_wr) st <= gen_seeded(seed);
    else if (step)    st <= gen_advance(st);
  end

  assign rnd = gen_output(st);

  // R5: state only moves on a step or a seed load
  a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !seed_wr) |=> $stable(st));
  // R4: after a step the top bit of w is always cleared
  a_r4_w_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seed_wr) |=> !st.w[WORD_W-1]);
endmodule

// File: rtl/sround_core.sv
`timescale 1ns/1ps
module sround_core #(
  parameter int unsigned OP_W  = 64,
  parameter int unsigned RES_W = 32,
  parameter int unsigned SH_W  = 5,
  parameter int unsigned RND_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [OP_W-1:0]  op,
  input  logic [SH_W-1:0]  sh,
  input  logic [RND_W-1:0] rnd,
  output logic             busy,
  output logic             use_rnd,
  output logic [RES_W-1:0] res,
  output logic             sat
);
  localparam int unsigned SUM_W = OP_W + 1;
  localparam int unsigned TOP_W = SUM_W - RES_W + 1;
  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  function automatic logic [RND_W-1:0] keep_low(input logic [RND_W-1:0] r,
                                                input logic [SH_W-1:0]  n);
    logic [RND_W-1:0] m;
    m = (RND_W'(1) << n) - RND_W'(1);
    return r & m;
  endfunction

  function automatic logic [SUM_W-1:0] widen_add(input logic [OP_W-1:0]  x,
                                                 input logic [RND_W-1:0] a);
    return {x[OP_W-1], x} + SUM_W'(a);
  endfunction

  function automatic logic [SUM_W-1:0] shift_down(input logic [SUM_W-1:0] v,
                                                  input logic [SH_W-1:0]  n);
    logic signed [SUM_W-1:0] s;
    s = $signed(v) >>> n;
    return s;
  endfunction

  function automatic logic [RES_W:0] clamp(input logic [SUM_W-1:0] v);
    logic [TOP_W-1:0] top;
    top = v[SUM_W-1:RES_W-1];
    if (top == '0 || top == '1) return {1'b0, v[RES_W-1:0]};
    else if (v[SUM_W-1])        return {1'b1, RES_MIN};
    else                        return {1'b1, RES_MAX};
  endfunction

  logic             a_v, done;
  logic [SUM_W-1:0] sum_q;
  logic [SH_W-1:0]  sh_a_q;
  logic [RND_W-1:0] addend;

  assign addend  = keep_low(rnd, sh);
  assign use_rnd = go && (sh != '0);
  assign busy    = go || a_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v    <= 1'b0;
      done   <= 1'b0;
      sum_q  <= '0;
      sh_a_q <= '0;
      res    <= '0;
      sat    <= 1'b0;
    end else begin
      a_v  <= go;
      done <= a_v;
      if (go) begin
        sum_q  <= widen_add(op, addend);
        sh_a_q <= sh;
      end
      if (a_v) {sat, res} <= clamp(shift_down(sum_q, sh_a_q));
    end
  end

  // R8: an operation moves through exactly two stages
  a_r8_stage_a: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> a_v);
  a_r8_finish: assert property (@(posedge clk) disable iff (!rst_n)
    a_v |=> (done && !a_v));
  // R7: a flagged result is one of the two limit codes
  a_r7_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sat) |-> (res == RES_MAX || res == RES_MIN));
  // R6: a zero shift adds nothing to the operand
  a_r6_no_addend: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sh == '0) |=> (sum_q == {$past(op[OP_W-1]), $past(op)}));
endmodule

// File: rtl/sround_regs.sv
`timescale 1ns/1ps
module sround_regs
  import sround_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OP_W   = 64,
  parameter int unsigned RES_W  = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [WORD_W-1:0] hwdata,
  output logic [WORD_W-1:0] hrdata,
  input  logic              busy,
  input  logic [RES_W-1:0]  res,
  input  logic              sat,
  output logic [OP_W-1:0]   op,
  output logic [SH_W-1:0]   sh,
  output logic              go,
  output logic              seed_wr,
  output logic [WORD_W-1:0] seed
);
  localparam int unsigned NWORDS = OP_W / WORD_W;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_SH   = IDX_W'(NWORDS);
  localparam logic [IDX_W-1:0] IDX_RES  = IDX_W'(NWORDS + 1);
  localparam logic [IDX_W-1:0] IDX_ST   = IDX_W'(NWORDS + 2);
  localparam logic [IDX_W-1:0] IDX_SEED = IDX_W'(NWORDS + 3);

  logic             xfer, ph_wr, ph_rd, wr_sh;
  logic [IDX_W-1:0] ph_idx;

  assign xfer = hsel && hready && (htrans inside {2'b10, 2'b11});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_wr  <= 1'b0;
      ph_rd  <= 1'b0;
      ph_idx <= '0;
    end else begin
      ph_wr <= xfer && hwrite;
      ph_rd <= xfer && !hwrite;
      if (xfer) ph_idx <= IDX_W'(haddr >> 2);
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 word_q <= '0;
      else if (ph_wr && ph_idx == IDX_W'(g))      word_q <= hwdata;
    end
    assign op[g*WORD_W +: WORD_W] = word_q;
  end

  assign wr_sh   = ph_wr && (ph_idx == IDX_SH);
  assign seed_wr = ph_wr && (ph_idx == IDX_SEED);
  assign seed    = hwdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      go <= 1'b0;
    end else begin
      go <= wr_sh && !busy;
      if (wr_sh && !busy) sh <= hwdata[SH_W-1:0];
    end
  end

  always_comb begin
    hrdata = '0;
    if (ph_rd) begin
      for (int k = 0; k < NWORDS; k++)
        if (ph_idx == IDX_W'(k)) hrdata = op[k*WORD_W +: WORD_W];
      if (ph_idx == IDX_SH)  hrdata = WORD_W'(sh);
      if (ph_idx == IDX_RES) hrdata = WORD_W'(res);
      if (ph_idx == IDX_ST)  hrdata = {{(WORD_W-2){1'b0}}, sat, busy};
    end
  end

  // R9: a count write during an operation changes nothing
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh && busy) |=> ($stable(sh) && !go));
  // R8: an accepted count write raises busy on the next cycle
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh && !busy) |=> busy);
endmodule

// File: rtl/sround_sat_unit.sv
`timescale 1ns/1ps
module sround_sat_unit
  import sround_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OP_W   = 64,
  parameter int unsigned RES_W  = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata,
  output logic              hreadyout,
  output logic              hresp
);
  logic              busy, go, use_rnd, sat, seed_wr;
  logic [RES_W-1:0]  res;
  logic [OP_W-1:0]   op;
  logic [SH_W-1:0]   sh;
  logic [WORD_W-1:0] seed, rnd;

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  sround_regs #(.ADDR_W(ADDR_W), .OP_W(OP_W), .RES_W(RES_W), .SH_W(SH_W)) u_regs (
    .clk(hclk), .rst_n(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
    .busy(busy), .res(res), .sat(sat), .op(op), .sh(sh), .go(go),
    .seed_wr(seed_wr), .seed(seed)
  );

  sround_prng u_prng (
    .clk(hclk), .rst_n(hresetn), .seed_wr(seed_wr), .seed(seed),
    .step(use_rnd), .rnd(rnd)
  );

  sround_core #(.OP_W(OP_W), .RES_W(RES_W), .SH_W(SH_W), .RND_W(WORD_W)) u_core (
    .clk(hclk), .rst_n(hresetn), .go(go), .op(op), .sh(sh), .rnd(rnd),
    .busy(busy), .use_rnd(use_rnd), .res(res), .sat(sat)
  );
endmodule

// File: tb/sim_sround_sat_unit.sv
`timescale 1ns/1ps
module sim_sround_sat_unit;
  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_SH = 8'h08,
                         A_RES = 8'h0C, A_ST = 8'h10, A_SEED = 8'h14;

  logic hclk = 1'b0;
  always #10 hclk = ~hclk;

  logic        hresetn, hsel, hwrite, hready, hreadyout, hresp;
  logic [7:0]  haddr;
  logic [1:0]  htrans;
  logic [31:0] hwdata, hrdata;

  sround_sat_unit u0 (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [31:0] res; logic sat; string tag; } item_t;
  item_t exp_q[$], obs_q[$];
  event  obs_ev;
  logic [31:0] last_res;

  int unsigned mx, my, mz, mw;
  bit          mc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference generator, written from R4/R10
  task automatic m_seed(input int unsigned s);
    mx = s; my = 987654321; mz = 43219876; mw = 6543217; mc = 0;
  endtask
  task automatic m_step();
    int unsigned t;
    my = my ^ (my << 5); my = my ^ (my >> 7); my = my ^ (my << 22);
    t  = mz + mw + (mc ? 1 : 0);
    mz = mw; mc = t[31]; mw = t & 32'h7fffffff;
    mx = mx + 32'd1411392427;
  endtask

  // reference rounding, written from R3/R6/R7
  task automatic m_round(input logic [63:0] op, input int sh,
                         output logic [31:0] r, output logic s);
    logic signed [95:0] v;
    logic [63:0] add;
    int unsigned rv;
    rv  = mx + my + mw;
    add = (sh == 0) ? 64'd0 : ({32'd0, rv} & ((64'd1 << sh) - 64'd1));
    v   = $signed({{32{op[63]}}, op}) + $signed({32'd0, add});
    v   = v >>> sh;
    if (v > 96'sd2147483647)       begin r = 32'h7fffffff; s = 1'b1; end
    else if (v < -96'sd2147483648) begin r = 32'h80000000; s = 1'b1; end
    else                           begin r = v[31:0];      s = 1'b0; end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge hclk);
    hsel = 1; haddr = a; htrans = 2'b10; hwrite = 1;
    @(negedge hclk);
    hsel = 0; htrans = 2'b00; hwrite = 0; hwdata = d;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge hclk);
    hsel = 1; haddr = a; htrans = 2'b10; hwrite = 0;
    @(negedge hclk);
    hsel = 0; htrans = 2'b00;
    d = hrdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] st;
    bit idle = 0;
    for (int i = 0; i < 20 && !idle; i++) begin
      bus_read(A_ST, st);
      idle = !st[0];
    end
    if (!idle) check(0, req, "busy never cleared", 1, 0);
  endtask

  task automatic collect(input string tag);
    logic [31:0] rd;
    item_t o;
    bus_read(A_RES, rd); o.res = rd;
    bus_read(A_ST, rd);  o.sat = rd[1];
    o.tag = tag;
    last_res = o.res;
    obs_q.push_back(o);
    -> obs_ev;
  endtask

  task automatic predict(input logic [63:0] op, input int sh, input string tag);
    item_t e;
    m_round(op, sh, e.res, e.sat);
    if (sh != 0) m_step();
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_round(input logic [63:0] op, input int sh, input string tag);
    predict(op, sh, tag);
    bus_write(A_LO, op[31:0]);
    bus_write(A_HI, op[63:32]);
    bus_write(A_SH, 32'(sh));
    wait_idle(tag);
    collect(tag);
  endtask

  // monitor: pops scoreboard pairs as results appear
  initial begin
    item_t o, e;
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        check(o.res == e.res, e.tag, "result", {32'd0, o.res}, {32'd0, e.res});
        check(o.sat == e.sat, e.tag, "sat flag", {63'd0, o.sat}, {63'd0, e.sat});
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] run1 [3];
    int ups;
    hresetn = 0; hsel = 0; hwrite = 0; hready = 1; haddr = '0; htrans = '0; hwdata = '0;
    m_seed(32'd123456789);
    repeat (3) @(posedge hclk);
    @(negedge hclk) hresetn = 1;

    // R1 reset state
    bus_read(A_RES, rd); check(rd == 0, "R1", "result after reset", rd, 0);
    bus_read(A_ST, rd);  check(rd == 0, "R1", "status after reset", rd, 0);
    bus_read(A_SH, rd);  check(rd == 0, "R1", "shift after reset", rd, 0);

    // R2 operand readback and bus response
    bus_write(A_LO, 32'hA5A5_1234); bus_write(A_HI, 32'h0F0F_8765);
    bus_read(A_LO, rd); check(rd == 32'hA5A5_1234, "R2", "low word", rd, 32'hA5A5_1234);
    bus_read(A_HI, rd); check(rd == 32'h0F0F_8765, "R2", "high word", rd, 32'h0F0F_8765);
    bus_read(A_SEED, rd); check(rd == 0, "R2", "seed reads zero", rd, 0);
    check(hreadyout == 1 && hresp == 0, "R2", "ready/okay", {hreadyout, hresp}, 2'b10);

    // R8 busy timing: status read right after the count write
    predict(64'h0000_0000_0001_2345, 4, "R8");
    bus_write(A_LO, 32'h0001_2345); bus_write(A_HI, 32'h0);
    bus_write(A_SH, 32'd4);
    bus_read(A_ST, rd); check(rd[0] == 1, "R8", "busy one cycle after", rd, 1);
    bus_read(A_ST, rd); check(rd[0] == 0, "R8", "idle two cycles after", rd, 0);
    collect("R8");

    // R3/R4/R5 mixed patterns
    do_round(64'h0000_0000_1234_5678, 8, "R3");
    do_round(64'hFFFF_FFFF_FFFF_0001, 12, "R3");
    do_round(64'h0000_0012_3456_789A, 16, "R4");
    do_round(64'hFFFF_FF00_0000_0000, 31, "R4");
    do_round(64'h0000_0000_0000_0001, 1, "R5");

    // R6 zero shift, no generator step, then a consumer
    do_round(64'h0000_0000_7654_3210, 0, "R6");
    do_round(64'hFFFF_FFFF_8000_0000, 0, "R6");
    do_round(64'h0000_0000_0000_00FF, 5, "R5");

    // R7 saturation both ways and recovery
    do_round(64'h0000_0001_0000_0000, 0, "R7");
    do_round(64'hFFFF_FFFE_FFFF_FFFF, 0, "R7");
    do_round(64'h7FFF_FFFF_FFFF_FFFF, 31, "R7");
    do_round(64'h8000_0000_0000_0000, 20, "R7");
    do_round(64'h0000_0000_0000_0100, 4, "R7");

    // R9 a second count write lands while busy
    predict(64'h0000_0000_0000_ABCD, 3, "R9");
    bus_write(A_LO, 32'h0000_ABCD); bus_write(A_HI, 32'h0);
    bus_write(A_SH, 32'd3);
    bus_write(A_SH, 32'd9);
    wait_idle("R9");
    collect("R9");
    bus_read(A_SH, rd); check(rd == 3, "R9", "count kept", rd, 3);
    do_round(64'h0000_0000_0F00_0F00, 9, "R9");

    // R10 seed reload repeats the sequence
    bus_write(A_SEED, 32'hDEAD_BEEF); m_seed(32'hDEAD_BEEF);
    for (int i = 0; i < 3; i++) begin
      do_round(64'h0000_0000_0000_FFFF + 64'(i), 6 + i, "R10");
      run1[i] = last_res;
    end
    bus_write(A_SEED, 32'hDEAD_BEEF); m_seed(32'hDEAD_BEEF);
    for (int i = 0; i < 3; i++) begin
      do_round(64'h0000_0000_0000_FFFF + 64'(i), 6 + i, "R10");
      check(last_res == run1[i], "R10", "repeat run", last_res, run1[i]);
    end

    // R3 statistics: 0.75 rounds up about three times in four
    ups = 0;
    for (int i = 0; i < 40; i++) begin
      do_round(64'd3, 2, "R3");
      if (last_res == 1) ups++;
    end
    check(ups >= 18 && ups <= 39, "R3", "round-up count", ups, 30);

    repeat (4) @(posedge hclk);
    check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule